// File: doc/BRIEF.md
# Filtered PI Loop Controller

This block is the digital loop filter of an oscillator-disciplining loop. It is updated once per phase-error sample, which arrives with a valid strobe, typically once per second from a reference pulse. Each sample is first smoothed by a first-order low-pass stage. The smoothed error is then accumulated into an integral. The control word sent to the oscillator's tuning converter is an operating-point offset plus a proportional term on the smoothed error plus an integral term.

The three coefficients are fixed-point inputs. They are meant to be derived off-chip from one closed-loop pole r, placed as a triple root: alpha = 3(1-r), Kp = (1-r)/(dt*g) and Ki = (1-r)^2/(3*dt*g). Here dt is the sample spacing and g is the oscillator gain per control count. The intended g is about 229 µHz per count, measured on the doubled 20 MHz clock.

All three products go through a single shared multiplier, one product per cycle. The control word is clamped to the 16-bit unsigned range, and the integral stops moving while the clamp is active.

Top module: `pi_loop_filter`

## Requirements
- R1: While rst_n is low, ctrl_word and done are 0. The smoothed-error and integral states are cleared, so the first result after reset equals op_point exactly.
- R2: A sample is accepted at a rising edge where err_valid is 1 and the block is idle. ctrl_word is updated and done pulses high for one cycle on the fourth rising edge, counting the accept edge as the first. At all other times ctrl_word holds its value.
- R3: The result of a sample is op_point + floor((Kp*ef + Ki*ig) / 2^32). It is computed from the state as it stood before that sample. Kp and Ki are unsigned Q16.16 values; ef and ig are signed with 16 fraction bits.
- R4: After a sample e (a signed integer), the smoothed error becomes ef + floor(alpha*(e*2^16 - ef) / 2^16), where alpha is unsigned Q16.16.
- R5: After a sample, the integral becomes ig + ef, using the smoothed error from before that sample's filter update.
- R6: When the unclamped result is below 0 the word is 0. When it is above 2^OUT_W-1 the word is 2^OUT_W-1.
- R7: When the result of a sample is clamped, the integral keeps its previous value. The smoothed error is still updated.
- R8: The smoothed error and the integral saturate at the signed ACC_W-bit limits instead of wrapping.
- R9: An err_valid pulse that arrives while a sample is in progress is ignored. It produces no result and has no effect on the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_valid | input | 1 | Phase-error sample strobe |
| err_in | input | ERR_W | Signed integer phase error |
| alpha_cf | input | COEF_W | Low-pass coefficient, unsigned Q16.16 |
| kp_cf | input | COEF_W | Proportional gain, unsigned Q16.16 |
| ki_cf | input | COEF_W | Integral gain, unsigned Q16.16 |
| op_point | input | OUT_W | Operating-point offset added to the PI term |
| ctrl_word | output | OUT_W | Clamped oscillator control word |
| done | output | 1 | One-cycle pulse when ctrl_word is updated |

## Verification
The bench builds the block with ERR_W=24 and ACC_W=40, and leaves FRAC=16, COEF_W=32 and OUT_W=16 at their defaults. With that accumulator width, a full-scale error and an alpha of 3.0 drive the smoothed error to its rail in one sample and the integral to its rail in two. This makes the state saturation of R8 reachable from the ports. A one-count integral gain then reads the railed integral back through the control word. Output clamping at both ends and the integral freeze are exercised with gains a few counts wide, and the busy-time strobe case is driven in the middle of a sample.

// File: rtl/pi_loop_pkg.sv
package pi_loop_pkg;

    // Sequencer phases: one product is formed per busy phase.
    typedef enum logic [1:0] {
        PL_IDLE = 2'd0,
        PL_PROP = 2'd1,
        PL_INTG = 2'd2,
        PL_FILT = 2'd3
    } pl_state_e;

endpackage

// File: rtl/pl_mul.sv
// Shared signed multiplier, full-precision product.
module pl_mul #(
    parameter int A_W = 49,
    parameter int B_W = 33,
    localparam int P_W = A_W + B_W
) (
    input  logic signed [A_W-1:0] op_a,
    input  logic signed [B_W-1:0] op_b,
    output logic signed [P_W-1:0] prod
);
    assign prod = P_W'(op_a) * P_W'(op_b);
endmodule

// File: rtl/pl_sat_signed.sv
// Narrow a signed value to OUT_W bits, saturating at the signed limits.
module pl_sat_signed #(
    parameter int IN_W  = 49,
    parameter int OUT_W = 48
) (
    input  logic signed [IN_W-1:0]  din,
    output logic signed [OUT_W-1:0] dout
);
    generate
        if (IN_W > OUT_W) begin : g_narrow
            logic [IN_W-OUT_W:0] upper;
            logic                fits;
            assign upper = din[IN_W-1:OUT_W-1];
            assign fits  = (&upper) || !(|upper);
            always_comb begin
                if (fits)
                    dout = din[OUT_W-1:0];
                else if (din[IN_W-1])
                    dout = {1'b1, {(OUT_W-1){1'b0}}};
                else
                    dout = {1'b0, {(OUT_W-1){1'b1}}};
            end
        end else begin : g_wide
            assign dout = OUT_W'(din);
        end
    endgenerate
endmodule

// File: rtl/pl_clamp_out.sv
// Clamp a signed value to the unsigned OUT_W-bit range and flag clamping.
module pl_clamp_out #(
    parameter int IN_W  = 84,
    parameter int OUT_W = 16
) (
    input  logic signed [IN_W-1:0] din,
    output logic [OUT_W-1:0]       dout,
    output logic                   hit
);
    logic neg;
    logic over;

    assign neg  = din[IN_W-1];
    assign over = !neg && (|din[IN_W-2:OUT_W]);

    always_comb begin
        hit = neg || over;
        if (neg)
            dout = '0;
        else if (over)
            dout = '1;
        else
            dout = din[OUT_W-1:0];
    end
endmodule

// File: rtl/pi_loop_filter.sv
module pi_loop_filter
    import pi_loop_pkg::*;
#(
    parameter int ERR_W  = 32,
    parameter int COEF_W = 32,
    parameter int FRAC   = 16,
    parameter int ACC_W  = 48,
    parameter int OUT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_valid,
    input  logic [ERR_W-1:0]  err_in,
    input  logic [COEF_W-1:0] alpha_cf,
    input  logic [COEF_W-1:0] kp_cf,
    input  logic [COEF_W-1:0] ki_cf,
    input  logic [OUT_W-1:0]  op_point,
    output logic [OUT_W-1:0]  ctrl_word,
    output logic              done
);
    localparam int MA_W   = ACC_W + 1;     // operand A: state or filter difference
    localparam int MB_W   = COEF_W + 1;    // operand B: coefficient, zero-extended
    localparam int PROD_W = MA_W + MB_W;
    localparam int SUM_W  = PROD_W + 2;
    localparam int ESC_W  = ERR_W + FRAC;  // scaled error width

    typedef struct packed {
        pl_state_e                st;
        logic signed [ERR_W-1:0]  err;
        logic signed [ACC_W-1:0]  ef;
        logic signed [ACC_W-1:0]  ig;
        logic signed [PROD_W-1:0] pt;
        logic signed [PROD_W-1:0] it;
        logic [OUT_W-1:0]         word;
        logic                     done;
    } regs_t;

    regs_t q, d;

    logic signed [MA_W-1:0]     op_a;
    logic signed [MB_W-1:0]     op_b;
    logic signed [PROD_W-1:0]   prod;
    logic signed [MA_W-1:0]     err_scaled;
    logic signed [SUM_W-1:0]    total;
    logic signed [SUM_W-1:0]    total_int;
    logic [OUT_W-1:0]           clamp_word;
    logic                       clamp_hit;
    logic signed [PROD_W-1:0]   ef_step;
    logic signed [PROD_W:0]     ef_sum;
    logic signed [ACC_W-1:0]    ef_clip;
    logic signed [ACC_W:0]      ig_sum;
    logic signed [ACC_W-1:0]    ig_clip;
    pl_state_e                  st_w;
    logic signed [ACC_W-1:0]    ig_w;

    // Operand steering for the single multiplier.
    assign err_scaled = MA_W'($signed({q.err, {FRAC{1'b0}}}));

    always_comb begin
        op_a = MA_W'($signed(q.ef));
        op_b = $signed({1'b0, kp_cf});
        case (q.st)
            PL_INTG: begin
                op_a = MA_W'($signed(q.ig));
                op_b = $signed({1'b0, ki_cf});
            end
            PL_FILT: begin
                op_a = err_scaled - MA_W'($signed(q.ef));
                op_b = $signed({1'b0, alpha_cf});
            end
            default: ;
        endcase
    end

    pl_mul #(.A_W(MA_W), .B_W(MB_W)) u_mul (
        .op_a (op_a),
        .op_b (op_b),
        .prod (prod)
    );

    // Output path: offset + (Kp*ef + Ki*ig) / 2^(2*FRAC), clamped.
    assign total = SUM_W'($signed(q.pt)) + SUM_W'($signed(q.it))
                 + $signed(SUM_W'({op_point, {(2*FRAC){1'b0}}}));
    assign total_int = total >>> (2 * FRAC);

    pl_clamp_out #(.IN_W(SUM_W), .OUT_W(OUT_W)) u_clamp (
        .din  (total_int),
        .dout (clamp_word),
        .hit  (clamp_hit)
    );

    // Low-pass update: ef + alpha*(e - ef), saturated.
    assign ef_step = prod >>> FRAC;
    assign ef_sum  = (PROD_W+1)'($signed(q.ef)) + (PROD_W+1)'(ef_step);

    pl_sat_signed #(.IN_W(PROD_W+1), .OUT_W(ACC_W)) u_sat_ef (
        .din  (ef_sum),
        .dout (ef_clip)
    );

    // Integral update with the pre-update smoothed error, saturated.
    assign ig_sum = (ACC_W+1)'($signed(q.ig)) + (ACC_W+1)'($signed(q.ef));

    pl_sat_signed #(.IN_W(ACC_W+1), .OUT_W(ACC_W)) u_sat_ig (
        .din  (ig_sum),
        .dout (ig_clip)
    );

    // Next-state logic.
    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            PL_IDLE: begin
                if (err_valid) begin
                    d.err = $signed(err_in);
                    d.st  = PL_PROP;
                end
            end
            PL_PROP: begin
                d.pt = prod;
                d.st = PL_INTG;
            end
            PL_INTG: begin
                d.it = prod;
                d.st = PL_FILT;
            end
            PL_FILT: begin
                d.word = clamp_word;
                d.done = 1'b1;
                d.ef   = ef_clip;
                if (!clamp_hit)
                    d.ig = ig_clip;
                d.st = PL_IDLE;
            end
            default: d.st = PL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    assign ctrl_word = q.word;
    assign done      = q.done;
    assign st_w      = q.st;
    assign ig_w      = q.ig;

endmodule

// File: rtl/pi_loop_filter_chk.sv
module pi_loop_filter_chk
    import pi_loop_pkg::*;
#(
    parameter int ACC_W = 48,
    parameter int OUT_W = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    err_valid,
    input logic                    done,
    input logic [OUT_W-1:0]        ctrl_word,
    input pl_state_e               state,
    input logic signed [ACC_W-1:0] integ,
    input logic                    clamp_hit
);
    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("done wider than one cycle");

    p_done_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(err_valid, 4) && $past(state, 4) == PL_IDLE))
        else $error("done without an accepted sample four edges earlier");

    p_word_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(ctrl_word))
        else $error("ctrl_word changed without done");

    p_busy_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != PL_IDLE) |=> (state != PL_PROP))
        else $error("new sample started while busy");

    p_windup_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PL_FILT && clamp_hit) |=> $stable(integ))
        else $error("integral moved while output clamped");

    p_integ_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state != PL_FILT) |=> $stable(integ))
        else $error("integral moved outside the update phase");
endmodule

bind pi_loop_filter pi_loop_filter_chk #(.ACC_W(ACC_W), .OUT_W(OUT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .err_valid (err_valid),
    .done      (done),
    .ctrl_word (ctrl_word),
    .state     (st_w),
    .integ     (ig_w),
    .clamp_hit (clamp_hit)
);

// File: tb/pi_loop_filter_tb_top.sv
module pi_loop_filter_tb_top;
    localparam int ERR_W  = 24;
    localparam int COEF_W = 32;
    localparam int FRAC   = 16;
    localparam int ACC_W  = 40;
    localparam int OUT_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              err_valid = 1'b0;
    logic [ERR_W-1:0]  err_in = '0;
    logic [COEF_W-1:0] alpha_cf = '0;
    logic [COEF_W-1:0] kp_cf = '0;
    logic [COEF_W-1:0] ki_cf = '0;
    logic [OUT_W-1:0]  op_point = '0;
    logic [OUT_W-1:0]  ctrl_word;
    logic              done;

    int total = 0;
    int bad   = 0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    logic signed [127:0] m_ef = '0;
    logic signed [127:0] m_ig = '0;

    always #5 clk = ~clk;

    pi_loop_filter #(
        .ERR_W(ERR_W), .COEF_W(COEF_W), .FRAC(FRAC), .ACC_W(ACC_W), .OUT_W(OUT_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_in(err_in),
        .alpha_cf(alpha_cf), .kp_cf(kp_cf), .ki_cf(ki_cf), .op_point(op_point),
        .ctrl_word(ctrl_word), .done(done)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic signed [127:0] clip_acc(input logic signed [127:0] x);
        logic signed [127:0] lim;
        lim = 128'sd1 <<< (ACC_W - 1);
        if (x >= lim) return lim - 1;
        if (x < -lim) return -lim;
        return x;
    endfunction

    // Reference model of one sample, straight from the requirements.
    task automatic predict(input int e, output logic [15:0] w);
        logic signed [127:0] pt, it, tot, u, dif, stp, nef, nig;
        bit sat;
        pt  = m_ef * $signed({96'd0, kp_cf});
        it  = m_ig * $signed({96'd0, ki_cf});
        tot = pt + it + ($signed({112'd0, op_point}) <<< (2 * FRAC));
        u   = tot >>> (2 * FRAC);
        sat = 1'b0;
        if (u < 0) begin w = 16'd0; sat = 1'b1; end
        else if (u > 65535) begin w = 16'hFFFF; sat = 1'b1; end
        else w = u[15:0];
        dif = ($signed(128'(e)) <<< FRAC) - m_ef;
        stp = (dif * $signed({96'd0, alpha_cf})) >>> FRAC;
        nef = clip_acc(m_ef + stp);
        nig = clip_acc(m_ig + m_ef);
        if (!sat) m_ig = nig;
        m_ef = nef;
    endtask

    // Driver: predict, queue, strobe, and check the done timing (R2).
    task automatic send(input int e, input string tag);
        logic [15:0] w;
        predict(e, w);
        exp_q.push_back(w);
        tag_q.push_back(tag);
        @(negedge clk);
        err_valid = 1'b1;
        err_in    = ERR_W'(e);
        @(negedge clk);
        err_valid = 1'b0;
        @(negedge clk);
        check(done == 1'b0, "R2 done early", longint'(done), 0);
        @(negedge clk);
        check(done == 1'b0, "R2 done early", longint'(done), 0);
        @(negedge clk);
        check(done == 1'b1, "R2 done latency", longint'(done), 1);
        @(negedge clk);
        check(done == 1'b0, "R2 done width", longint'(done), 0);
    endtask

    // Strobe held through the busy phases with a different value (R9).
    task automatic send_busy(input int e, input int junk);
        logic [15:0] w;
        predict(e, w);
        exp_q.push_back(w);
        tag_q.push_back("R9 busy strobe");
        @(negedge clk);
        err_valid = 1'b1;
        err_in    = ERR_W'(e);
        @(negedge clk);
        err_in    = ERR_W'(junk);
        @(negedge clk);
        @(negedge clk);
        err_valid = 1'b0;
        @(negedge clk);
        check(done == 1'b1, "R9 sample result", longint'(done), 1);
        repeat (8) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        m_ef  = '0;
        m_ig  = '0;
        repeat (2) @(negedge clk);
        check(ctrl_word == 16'd0, "R1 reset word", longint'(ctrl_word), 0);
        check(done == 1'b0, "R1 reset done", longint'(done), 0);
        rst_n = 1'b1;
    endtask

    // Monitor: pops expected words as results appear.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected result", longint'(ctrl_word), -1);
            end else begin
                logic [15:0] ew;
                string       tg;
                ew = exp_q.pop_front();
                tg = tag_q.pop_front();
                check(ctrl_word == ew, tg, longint'(ctrl_word), longint'(ew));
            end
        end
    end

    task automatic finish_run();
        check(exp_q.size() == 0, "R2 missing results", longint'(exp_q.size()), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        // Normal tracking: alpha 0.75, Kp 2.0, Ki 0.25, offset 30000.
        alpha_cf = 32'h0000_C000;
        kp_cf    = 32'h0002_0000;
        ki_cf    = 32'h0000_4000;
        op_point = 16'd30000;
        do_reset();
        send(1000, "R3 first result equals offset");
        check(ctrl_word == 16'd30000, "R1 R3 first word", longint'(ctrl_word), 30000);
        send(1000, "R4 filtered proportional");
        check(ctrl_word == 16'd31500, "R4 second word", longint'(ctrl_word), 31500);
        send(-400, "R5 integral");
        send(250, "R5 integral");
        send(7, "R4 small error");
        send(-3, "R4 negative floor");
        send(0, "R3 zero error");
        send(1234, "R5 accumulated");
        send_busy(-777, 5000000);
        send(55, "R9 state after busy strobe");
        send(0, "R9 state after busy strobe");

        // Output clamps at both ends.
        alpha_cf = 32'h0001_0000;
        kp_cf    = 32'h0001_0000;
        ki_cf    = 32'h0000_0000;
        op_point = 16'd65000;
        do_reset();
        send(20000, "R6 clamp setup");
        send(20000, "R6 clamp high");
        check(ctrl_word == 16'hFFFF, "R6 high rail", longint'(ctrl_word), 65535);
        op_point = 16'd100;
        send(-50000, "R6 clamp low setup");
        send(0, "R6 clamp low");
        check(ctrl_word == 16'd0, "R6 low rail", longint'(ctrl_word), 0);

        // Anti-windup: integral only, offset near the top.
        alpha_cf = 32'h0001_0000;
        kp_cf    = 32'h0000_0000;
        ki_cf    = 32'h0001_0000;
        op_point = 16'd60000;
        do_reset();
        for (int i = 0; i < 5; i++) send(3000, "R7 windup drive");
        send(-2000, "R7 recovery");
        send(-2000, "R7 recovery");
        send(0, "R7 recovery");
        send(0, "R7 recovery");

        // Accumulator rails with a wide error range.
        alpha_cf = 32'h0003_0000;
        kp_cf    = 32'h0000_0000;
        ki_cf    = 32'h0000_0000;
        op_point = 16'd100;
        do_reset();
        send(8388607, "R8 ef rail");
        send(8388607, "R8 integral grows");
        send(8388607, "R8 integral rail");
        ki_cf = 32'h0000_0001;
        send(0, "R8 integral readback");
        check(ctrl_word == 16'd227, "R8 railed integral", longint'(ctrl_word), 227);
        kp_cf = 32'h0000_0001;
        ki_cf = 32'h0000_0000;
        send(-8388608, "R8 ef readback");
        send(-8388608, "R8 ef low rail");
        send(0, "R8 ef low readback");

        repeat (6) @(negedge clk);
        finish_run();
    end
endmodule